// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits between a synchronous host and an asynchronous DRAM with extended data out and a 4-bit data bus. It accepts one word request at a time over a valid/ready handshake. Each request carries a 22-bit word address, a write flag and 4 bits of write data. The controller splits the address into an 11-bit row (upper bits) and an 11-bit column (lower bits). Both halves go out in turn on the same 11 address pins, framed by the row strobe, the column strobe, the write strobe and the output-enable strobe. All strobes are active low.

After an access the row stays open, with the row strobe held low. When the next request targets the same row, only a column cycle is issued (page mode). When it targets another row, the row is closed and precharged, then the new row is opened. Read data is captured at the end of the column-strobe high phase. This relies on the extended-data-out property: the output stays valid after the column strobe rises.

Every interval is a clock count derived from nanosecond parameters. At the default 5 ns clock these counts are: precharge 6, row-to-column 6, column low 3, column high 1. A refresh request closes the open row at the next idle boundary. The strobes are then handed to an external refresh engine until it reports completion.

Top module: `edo_dram_ctl`

## Requirements
- R1: During and right after reset, all four strobes are high (inactive), data drive is off, rd_valid is low, req_ready is high and no row is open.
- R2: A request's row (req_addr[21:11]) is on dram_addr when the row strobe falls. Its column (req_addr[10:0]) is on dram_addr when the column strobe falls.
- R3: A request that misses the open row, or finds no row open, raises the row strobe for exactly 6 cycles when a row was open (at least 6 otherwise). It then holds the row strobe low for 6 cycles before the column strobe falls. Exactly one row activation results. The completion latency is 6+6+3+1 = 16 cycles after the accepting edge.
- R4: A request that hits the open row produces no row-strobe activity. The column strobe falls on the cycle after acceptance, and the completion latency is 3+1 = 4 cycles.
- R5: A read holds the write strobe high and the output-enable strobe low through its column cycle. Data is sampled while the column strobe is high again (extended data out). rd_data is returned with a rd_valid pulse one cycle wide.
- R6: A write holds the write strobe low and the output-enable strobe high. It drives dram_dq_out with the request data and sets dram_dq_oe for the whole column cycle. dram_dq_oe is never set while the output-enable strobe is low.
- R7: A refresh request seen when idle closes the row and raises ref_grant. While granted, all strobes stay high and req_ready stays low. When ref_done arrives the controller returns to idle with no row open, so the next access is a miss.
- R8: The column strobe is never low while the row strobe is high.
- R9: req_ready is high only when the controller is idle and no refresh is requested. Data written through the controller reads back unchanged across page hits, row misses, address extremes and refreshes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 22 | Word address, row in upper 11 bits |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle read data valid pulse |
| rd_data | output | 4 | Read data |
| ref_req | input | 1 | Refresh engine wants the strobes |
| ref_grant | output | 1 | Strobes handed to refresh engine |
| ref_done | input | 1 | Refresh engine finished |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output-enable strobe, active low |
| dram_dq_out | output | 4 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 4 | Data returned by the DRAM |

## Verification
A runs of page hits within one row, walking across the columns, separates page-cycle timing from full row cycles. Alternating rows force a precharge and activation on every access and check the measured precharge and row-to-column intervals. The address extremes (all zeros, all ones) prove the row/column split. A pseudo-random mix over a few rows, with a refresh in the middle, checks data integrity. The bench's memory model drives inverted data whenever the extended-data-out hold condition fails, so sampling outside the valid window shows up as a data mismatch.

// File: rtl/edo_ctl_pkg.sv
`timescale 1ns/1ps
// Shared types for the EDO DRAM controller.
package edo_ctl_pkg;
    // Controller phase; each non-idle phase is timed by the phase timer.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRECHARGE,
        PH_ROWOPEN,
        PH_COLLOW,
        PH_COLHIGH,
        PH_REFRESH
    } phase_e;
endpackage

// File: rtl/edo_phase_timer.sv
`timescale 1ns/1ps
// Down-counter that times one controller phase.
// Assumes: len >= 1 whenever load is pulsed; expired is high on the last
// cycle of a phase that was loaded with len cycles.
module edo_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    // Load the phase length minus one, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= len - CW'(1);
        else if (cnt_q != 0) cnt_q <= cnt_q - CW'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/edo_row_tracker.sv
`timescale 1ns/1ps
// Remembers which row, if any, is held open and compares it with a request.
// Assumes: open_set and close are never asserted in the same cycle.
module edo_row_tracker #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_set,
    input  logic [ROW_W-1:0] set_row,
    input  logic             close,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             is_open,
    output logic             hit
);
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    // Track the open row: set on activation, cleared on precharge or refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (open_set) begin
            open_q <= 1'b1;
            row_q  <= set_row;
        end else if (close) begin
            open_q <= 1'b0;
        end
    end

    assign is_open = open_q;
    assign hit     = open_q && (row_q == cmp_row);
endmodule

// File: rtl/edo_strobe_decode.sv
`timescale 1ns/1ps
// Decodes registered controller state into DRAM strobes, address and data drive.
// Assumes: all inputs come straight from registers, so outputs are glitch-free
// at board level once setup margins are met.
module edo_strobe_decode
    import edo_ctl_pkg::*;
#(
    parameter int ROW_W = 11,
    parameter int COL_W = 11,
    parameter int PIN_W = 11,
    parameter int DW    = 4
) (
    input  phase_e           phase,
    input  logic             row_open,
    input  logic             wr,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [DW-1:0]    wdata,
    output logic [PIN_W-1:0] addr,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             oe_n,
    output logic [DW-1:0]    dq_out,
    output logic             dq_oe
);
    logic col_phase;

    // Strobe and bus levels per phase.
    always_comb begin
        col_phase = (phase == PH_COLLOW) || (phase == PH_COLHIGH);
        addr      = col_phase ? PIN_W'(col) : PIN_W'(row);
        unique case (phase)
            PH_IDLE:                         ras_n = !row_open;
            PH_ROWOPEN, PH_COLLOW, PH_COLHIGH: ras_n = 1'b0;
            default:                         ras_n = 1'b1;
        endcase
        cas_n  = (phase != PH_COLLOW);
        we_n   = !(col_phase && wr);
        oe_n   = !(col_phase && !wr);
        dq_oe  = col_phase && wr;
        dq_out = (col_phase && wr) ? wdata : '0;
    end
endmodule

// File: rtl/edo_dram_ctl.sv
`timescale 1ns/1ps
// EDO page-mode DRAM controller top.
// Accepts one word request at a time, keeps the last row open, issues page
// column cycles on row hits and precharge+activate on misses, samples read
// data during the column-strobe high phase, and yields the strobes to an
// external refresh engine on request. Assumes the DRAM model honours the
// extended-data-out hold while RAS and OE are low and WE is high.
module edo_dram_ctl
    import edo_ctl_pkg::*;
#(
    parameter int ROW_W   = 11,
    parameter int COL_W   = 11,
    parameter int DW      = 4,
    parameter int CLK_NS  = 5,
    parameter int RP_NS   = 30,
    parameter int RCD_NS  = 28,
    parameter int CAC_NS  = 13,
    parameter int PC_NS   = 20,
    parameter int CW      = 8,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DW-1:0]     req_wdata,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    input  logic              ref_req,
    output logic              ref_grant,
    input  logic              ref_done,
    output logic [PIN_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DW-1:0]     dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DW-1:0]     dram_dq_in
);
    localparam int RP_CYC   = (RP_NS + CLK_NS - 1) / CLK_NS;
    localparam int RCD_CYC  = (RCD_NS + CLK_NS - 1) / CLK_NS;
    localparam int CAS_CYC  = (CAC_NS + CLK_NS - 1) / CLK_NS;
    localparam int PC_CYC   = (PC_NS + CLK_NS - 1) / CLK_NS;
    localparam int CP_CYC   = (PC_CYC > CAS_CYC) ? PC_CYC - CAS_CYC : 1;
    localparam logic [CW-1:0] RP_L  = CW'(RP_CYC);
    localparam logic [CW-1:0] RCD_L = CW'(RCD_CYC);
    localparam logic [CW-1:0] CAS_L = CW'(CAS_CYC);
    localparam logic [CW-1:0] CP_L  = CW'(CP_CYC);

    phase_e           phase_q, phase_d;
    logic             wr_q;
    logic [DW-1:0]    wdata_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             t_load, t_exp;
    logic [CW-1:0]    t_len;
    logic             trk_set, trk_close, trk_open, trk_hit;
    logic             capture, accept;

    edo_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .len(t_len), .expired(t_exp)
    );

    edo_row_tracker #(.ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .open_set(trk_set), .set_row(row_q), .close(trk_close),
        .cmp_row(req_addr[ADDR_W-1:COL_W]),
        .is_open(trk_open), .hit(trk_hit)
    );

    edo_strobe_decode #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W), .DW(DW)) u_strobes (
        .phase(phase_q), .row_open(trk_open), .wr(wr_q),
        .row(row_q), .col(col_q), .wdata(wdata_q),
        .addr(dram_addr), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
        .we_n(dram_we_n), .oe_n(dram_oe_n),
        .dq_out(dram_dq_out), .dq_oe(dram_dq_oe)
    );

    assign req_ready = (phase_q == PH_IDLE) && !ref_req;
    assign accept    = req_ready && req_valid;
    assign ref_grant = (phase_q == PH_REFRESH);

    // Next phase, timer loads and row-tracker updates.
    always_comb begin
        phase_d   = phase_q;
        t_load    = 1'b0;
        t_len     = CW'(1);
        trk_set   = 1'b0;
        trk_close = 1'b0;
        capture   = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (ref_req) begin
                    phase_d   = PH_REFRESH;
                    trk_close = 1'b1;
                end else if (req_valid) begin
                    t_load = 1'b1;
                    if (trk_hit) begin
                        phase_d = PH_COLLOW;
                        t_len   = CAS_L;
                    end else begin
                        phase_d   = PH_PRECHARGE;
                        t_len     = RP_L;
                        trk_close = 1'b1;
                    end
                end
            end
            PH_PRECHARGE: if (t_exp) begin
                phase_d = PH_ROWOPEN;
                t_load  = 1'b1;
                t_len   = RCD_L;
                trk_set = 1'b1;
            end
            PH_ROWOPEN: if (t_exp) begin
                phase_d = PH_COLLOW;
                t_load  = 1'b1;
                t_len   = CAS_L;
            end
            PH_COLLOW: if (t_exp) begin
                phase_d = PH_COLHIGH;
                t_load  = 1'b1;
                t_len   = CP_L;
            end
            PH_COLHIGH: if (t_exp) begin
                phase_d = PH_IDLE;
                capture = !wr_q;
            end
            PH_REFRESH: if (ref_done) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register, request latch and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            wr_q     <= 1'b0;
            wdata_q  <= '0;
            row_q    <= '0;
            col_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            phase_q  <= phase_d;
            rd_valid <= capture;
            if (accept) begin
                wr_q    <= req_we;
                wdata_q <= req_wdata;
                row_q   <= req_addr[ADDR_W-1:COL_W];
                col_q   <= req_addr[COL_W-1:0];
            end
            if (capture) rd_data <= dram_dq_in;
        end
    end

    // R8: column strobe only inside an open row.
    a_r8_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);
    // R6: data is driven only while writing with the output buffer disabled.
    a_r6_drive_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (!dram_we_n && dram_oe_n));
    // R7: strobes stay quiet and host is stalled while refresh owns the bus.
    a_r7_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ref_grant |-> (dram_ras_n && dram_cas_n && !req_ready && !dram_dq_oe));
    // R5: read valid is a single-cycle pulse.
    a_r5_rdvalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R4: a page hit starts its column cycle on the next cycle with the row held.
    a_r4_hit_goes_column: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && trk_hit) |=> (!dram_ras_n && !dram_cas_n));
endmodule

// File: tb/edo_dram_ctl_test.sv
`timescale 1ns/1ps
// Bench: behavioural EDO DRAM model plus a request-level reference model.
module edo_dram_ctl_test;
    localparam int RP = 6, RCD = 6, CASC = 3, CPC = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [21:0] req_addr = '0;
    logic [3:0] req_wdata = '0;
    logic ref_req = 1'b0, ref_done = 1'b0;
    logic req_ready, rd_valid, ref_grant;
    logic [3:0] rd_data, dq_out;
    logic [10:0] dram_addr;
    logic ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [3:0] dq_in = '0;

    int tests = 0, fails = 0;

    edo_dram_ctl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ref_req(ref_req), .ref_grant(ref_grant), .ref_done(ref_done),
        .dram_addr(dram_addr), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
        .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_dq_out(dq_out),
        .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
    );

    always #2.5 clk = ~clk;

    task automatic chk(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // DRAM model state
    logic [3:0] mem [int];
    logic [3:0] shadow [int];
    logic prev_ras = 1'b1, prev_cas = 1'b1, rd_hold = 1'b0;
    logic [10:0] lat_row = '0, lat_col = '0;
    int act_cnt = 0, hi_run = 0, hi_seen = 0, lo_run = 0, rcd_seen = 0;
    logic wr_strobe_bad = 1'b0;

    function automatic logic [3:0] mem_rd(int k);
        return mem.exists(k) ? mem[k] : 4'h0;
    endfunction

    // Behavioural EDO DRAM: strobe-edge latching, write on CAS fall, EDO hold.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !ras_n) begin
                act_cnt++;
                lat_row = dram_addr;
                hi_seen = hi_run;
                lo_run = 0;
            end
            if (ras_n) hi_run++; else hi_run = 0;
            if (!ras_n) begin
                if (prev_cas && !cas_n) rcd_seen = lo_run;
                lo_run++;
            end
            if (prev_cas && !cas_n) begin
                lat_col = dram_addr;
                if (!we_n) begin
                    if (!dq_oe) wr_strobe_bad = 1'b1;
                    mem[int'({lat_row, lat_col})] = dq_out;
                end
                rd_hold = we_n;
            end
            if (ras_n || oe_n || !we_n) rd_hold = 1'b0;
            dq_in = rd_hold ? mem_rd(int'({lat_row, lat_col}))
                            : ~mem_rd(int'({lat_row, lat_col}));
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    // Every-clock protocol checks.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(!cas_n && ras_n), "R8 cas low with ras high", cas_n, 1);
            chk(!(dq_oe && (!oe_n || we_n)), "R6 drive outside write", dq_oe, 0);
            chk(!(ref_grant && (!ras_n || !cas_n || req_ready)), "R7 grant not quiet",
                req_ready, 0);
            chk(!(req_ready && (ref_grant || ref_req)), "R9 ready while refresh", req_ready, 0);
        end
    end

    logic open_valid = 1'b0;
    logic [10:0] open_row = '0;

    task automatic do_req(logic [21:0] a, logic w, logic [3:0] d);
        int n, acts0, exp_lat;
        bit hit, was_open, done;
        while (!req_ready) @(negedge clk);
        hit = open_valid && (open_row == a[21:11]);
        was_open = open_valid;
        acts0 = act_cnt;
        req_valid = 1'b1; req_addr = a; req_we = w; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        done = 1'b0;
        while (!done && n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            done = w ? req_ready : rd_valid;
        end
        exp_lat = hit ? CASC + CPC : RP + RCD + CASC + CPC;
        chk(n == exp_lat, hit ? "R4 hit latency" : "R3 miss latency", n, exp_lat);
        chk(act_cnt - acts0 == (hit ? 0 : 1), hit ? "R4 no activation" : "R3 one activation",
            act_cnt - acts0, hit ? 0 : 1);
        if (!hit) begin
            chk(rcd_seen == RCD, "R3 row-to-column", rcd_seen, RCD);
            if (was_open) chk(hi_seen == RP, "R3 precharge", hi_seen, RP);
            else          chk(hi_seen >= RP, "R3 precharge min", hi_seen, RP);
        end
        chk(lat_row == a[21:11], "R2 row split", lat_row, a[21:11]);
        chk(lat_col == a[10:0], "R2 col split", lat_col, a[10:0]);
        if (w) begin
            shadow[int'(a)] = d;
            chk(!wr_strobe_bad, "R6 write without drive", wr_strobe_bad, 0);
        end else begin
            chk(rd_data == (shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0),
                "R5 R9 read data", rd_data,
                shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0);
            @(negedge clk);
            chk(!rd_valid, "R5 rd_valid one cycle", rd_valid, 0);
        end
        open_valid = 1'b1;
        open_row = a[21:11];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        logic [10:0] rows [4];
        rows[0] = 11'd3; rows[1] = 11'd3; rows[2] = 11'd900; rows[3] = 11'd2047;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(ras_n && cas_n && we_n && oe_n, "R1 strobes high", {ras_n, cas_n, we_n, oe_n}, 15);
        chk(!dq_oe && !rd_valid, "R1 no drive, no valid", {dq_oe, rd_valid}, 0);
        chk(req_ready, "R1 ready", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_n && !ref_grant, "R1 no row open after reset", ras_n, 1);

        // First access from closed, then page hits along one row
        do_req({11'd5, 11'd10}, 1'b1, 4'h9);
        do_req({11'd5, 11'd10}, 1'b0, 4'h0);
        for (int c = 0; c < 8; c++) do_req({11'd5, 11'(c)}, 1'b1, 4'(c * 3 + 1));
        for (int c = 0; c < 8; c++) do_req({11'd5, 11'(c)}, 1'b0, 4'h0);
        // Alternating rows: every access a miss
        do_req({11'd7, 11'd10}, 1'b1, 4'h6);
        do_req({11'd5, 11'd10}, 1'b0, 4'h0);
        do_req({11'd7, 11'd10}, 1'b0, 4'h0);
        // Address extremes
        do_req(22'h000000, 1'b1, 4'hC);
        do_req(22'h3FFFFF, 1'b1, 4'h3);
        do_req(22'h000000, 1'b0, 4'h0);
        do_req(22'h3FFFFF, 1'b0, 4'h0);

        // R7 refresh with a row open
        @(negedge clk);
        ref_req = 1'b1;
        @(negedge clk);
        chk(ref_grant, "R7 grant", ref_grant, 1);
        chk(ras_n && cas_n && !req_ready, "R7 strobes released", {ras_n, cas_n, req_ready}, 6);
        repeat (4) @(negedge clk);
        ref_done = 1'b1; ref_req = 1'b0;
        @(negedge clk);
        ref_done = 1'b0;
        chk(!ref_grant && ras_n && req_ready, "R7 back idle, row closed",
            {ref_grant, ras_n, req_ready}, 3);
        open_valid = 1'b0;
        do_req(22'h3FFFFF, 1'b0, 4'h0);

        // Pseudo-random mix over a few rows
        lf = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_req({rows[lf[1:0]], 5'd0, lf[7:2]}, lf[8], lf[12:9]);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule